// File: doc/BRIEF.md
# Transmit Line-Ending Translator

This block sits in the transmit path of a serial port, between the character queue and the shift-out logic. Both sides use a valid/ready byte stream. A two-bit mode input chooses how carriage-return (0x0D) and newline (0x0A) bytes are rewritten before transmission. All other bytes pass through unchanged.

One mode turns a single newline into two characters. The block then holds its input side off until both characters have left. The mode is taken when a byte is accepted, so a mode change never splits a two-character expansion. The output is one register stage: an accepted byte appears on the output in the next cycle. The input ready depends on the output ready only through that single stage.

Top module: `tx_eol_xlate`

## Requirements
- R1: After synchronous active-low reset, out_valid is 0 and in_ready is 1.
- R2: Mode 2'b00 passes every byte unchanged, including 0x0D and 0x0A.
- R3: Mode 2'b01 (bit 0 = CR-to-NL) emits each 0x0D as 0x0A. 0x0A and all other bytes pass unchanged.
- R4: Mode 2'b10 (bit 1 = NL-to-CRNL) emits each 0x0A as 0x0D followed by 0x0A. 0x0D passes unchanged.
- R5: Mode 2'b11 emits 0x0D as a single 0x0A, which is not expanded again, and emits 0x0A as 0x0D then 0x0A.
- R6: During an expansion the 0x0D is offered first. in_ready stays 0 until the downstream side has accepted the following 0x0A.
- R7: The mode is sampled when a byte is accepted. A later mode change does not alter the output of that byte, even in the middle of an expansion.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values on the next cycle.
- R9: in_ready is 0 whenever out_valid is 1 and out_ready is 0. When nothing is held and no expansion is pending, in_ready is 1.
- R10: A byte accepted while the output is empty or draining appears on out_data with out_valid = 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Bit 1: newline expansion; bit 0: carriage return to newline |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Upstream byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Translated byte |

## Verification
Two events can fall in the same cycle: a mode change, and the acceptance or expansion of a newline. The bench accepts a newline in an expanding mode and switches the mode to pass-through while the inserted carriage return is still stalled. It then checks that both characters still leave and that in_ready stays low throughout. A second overlap is a downstream handshake in the same cycle as a new upstream acceptance. This is provoked by back-to-back newlines and random bytes under random out_ready. A scoreboard judges it by comparing every output handshake against a model that takes the mode sampled at each input handshake.

// File: rtl/tx_eol_pkg.sv
// Shared types for the transmit line-ending translator.
// Assumes: an 8-bit character path and the usual control-code values.
package tx_eol_pkg;
    // Sequencer phase: idle, inserted CR on output, trailing NL on output
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CR   = 2'd1,
        PH_NL   = 2'd2
    } phase_t;

    localparam int unsigned MODE_W = 2;
    localparam int unsigned BIT_CR2NL = 0;
    localparam int unsigned BIT_NL2CRNL = 1;
endpackage

// File: rtl/tx_eol_classify.sv
// Decides, for one incoming byte and the current mode, what the first output
// byte is and whether a trailing NL must be inserted after it.
// Assumes: purely combinational; the caller samples the result on acceptance.
module tx_eol_classify #(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] CR_CODE = 8'h0D,
    parameter logic [DATA_W-1:0] NL_CODE = 8'h0A
) (
    input  logic [DATA_W-1:0]             byte_in,
    input  logic [tx_eol_pkg::MODE_W-1:0] mode,
    output logic [DATA_W-1:0]             first_out,
    output logic                          expand
);
    import tx_eol_pkg::*;

    logic is_cr;
    logic is_nl;

    // Recognise the two control codes.
    always_comb begin
        is_cr = (byte_in == CR_CODE);
        is_nl = (byte_in == NL_CODE);
    end

    // Choose the first emitted byte and the expansion flag.
    always_comb begin
        first_out = byte_in;
        expand    = 1'b0;
        if (is_cr && mode[BIT_CR2NL]) begin
            first_out = NL_CODE;
        end else if (is_nl && mode[BIT_NL2CRNL]) begin
            first_out = CR_CODE;
            expand    = 1'b1;
        end
    end
endmodule

// File: rtl/tx_eol_seq.sv
// Tracks an expansion in progress and asks for the trailing NL to be loaded.
// Assumes: the output register accepts a load in the same cycle it drains.
module tx_eol_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic in_fire,
    input  logic expand,
    input  logic out_fire,
    output logic idle,
    output logic load_nl
);
    import tx_eol_pkg::*;

    phase_t phase_q;
    phase_t phase_d;

    // Next-phase selection and trailing-NL load request.
    always_comb begin
        phase_d = phase_q;
        load_nl = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (in_fire && expand) phase_d = PH_CR;
            PH_CR: if (out_fire) begin
                phase_d = PH_NL;
                load_nl = 1'b1;
            end
            PH_NL: if (out_fire) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Idle flag for the input-ready decision.
    always_comb idle = (phase_q == PH_IDLE);
endmodule

// File: rtl/tx_eol_outreg.sv
// Single output holding register with valid flag.
// Assumes: load has priority over drain; data holds while not loaded.
module tx_eol_outreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drain,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    // Valid flag: set on load, cleared on drain without reload.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= 1'b0;
        else if (load)  valid <= 1'b1;
        else if (drain) valid <= 1'b0;
    end

    // Data register: only written on load, so it is stable while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (load) data <= load_data;
    end
endmodule

// File: rtl/tx_eol_xlate.sv
// Transmit line-ending translator top. Rewrites CR/NL per a two-bit mode and
// inserts a CR ahead of NL when expansion is selected, stalling the input.
// Assumes: mode is sampled on input acceptance; one output register stage.
module tx_eol_xlate #(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] CR_CODE = 8'h0D,
    parameter logic [DATA_W-1:0] NL_CODE = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              in_fire;
    logic              out_fire;
    logic              idle;
    logic              load_nl;
    logic              expand;
    logic [DATA_W-1:0] first_out;
    logic [DATA_W-1:0] load_data;

    tx_eol_classify #(
        .DATA_W (DATA_W),
        .CR_CODE(CR_CODE),
        .NL_CODE(NL_CODE)
    ) u_classify (
        .byte_in  (in_data),
        .mode     (mode),
        .first_out(first_out),
        .expand   (expand)
    );

    tx_eol_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_fire (in_fire),
        .expand  (expand),
        .out_fire(out_fire),
        .idle    (idle),
        .load_nl (load_nl)
    );

    tx_eol_outreg #(
        .DATA_W(DATA_W)
    ) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_fire | load_nl),
        .load_data(load_data),
        .drain    (out_fire),
        .valid    (out_valid),
        .data     (out_data)
    );

    // Handshake decode and the single-stage ready path.
    always_comb begin
        out_fire = out_valid & out_ready;
        in_ready = idle & (~out_valid | out_ready);
        in_fire  = in_valid & in_ready;
    end

    // Output load source: translated input byte or the trailing NL.
    always_comb load_data = load_nl ? NL_CODE : first_out;
endmodule

// File: rtl/tx_eol_xlate_chk.sv
// Property checker for the line-ending translator, bound to every instance.
// Assumes: observes top-level ports only; keeps its own expansion tracker.
module tx_eol_xlate_chk #(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] CR_CODE = 8'h0D,
    parameter logic [DATA_W-1:0] NL_CODE = 8'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    logic in_fire;
    logic out_fire;
    logic busy_q;

    always_comb begin
        in_fire  = in_valid & in_ready;
        out_fire = out_valid & out_ready;
    end

    // Tracks an expansion from NL acceptance until the trailing NL leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else if (in_fire && mode[1] && in_data == NL_CODE) busy_q <= 1'b1;
        else if (out_fire && out_data == NL_CODE) busy_q <= 1'b0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && mode == 2'b00) |=> (out_valid && out_data == $past(in_data)));

    // R3
    cr_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && mode[0] && in_data == CR_CODE) |=> (out_valid && out_data == NL_CODE));

    // R4
    expand_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && mode[1] && in_data == NL_CODE) |=> (out_valid && out_data == CR_CODE));

    // R6
    expand_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !in_ready);

    // R6
    expand_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && out_fire && out_data == CR_CODE) |=> (out_valid && out_data == NL_CODE));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    ready_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind tx_eol_xlate tx_eol_xlate_chk #(
    .DATA_W (DATA_W),
    .CR_CODE(CR_CODE),
    .NL_CODE(NL_CODE)
) u_chk (.*);

// File: tb/tx_eol_xlate_test.sv
`timescale 1ns/1ps
// Bench for the line-ending translator: vector table, then directed and random.
module tx_eol_xlate_test;
    localparam logic [7:0] CR = 8'h0D;
    localparam logic [7:0] NL = 8'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       in_fire_s, out_fire_s;
    logic [7:0] out_data_s;

    // {mode(8), input, first expected, second expected or 00 for none}
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {8'd0, 8'h41, 8'h41, 8'h00},
        {8'd0, CR,    CR,    8'h00},
        {8'd0, NL,    NL,    8'h00},
        {8'd1, CR,    NL,    8'h00},
        {8'd1, NL,    NL,    8'h00},
        {8'd1, 8'h7E, 8'h7E, 8'h00},
        {8'd2, NL,    CR,    NL},
        {8'd2, CR,    CR,    8'h00},
        {8'd2, 8'h00, 8'h00, 8'h00},
        {8'd3, CR,    NL,    8'h00},
        {8'd3, NL,    CR,    NL},
        {8'd3, 8'hFF, 8'hFF, 8'h00}
    };

    tx_eol_xlate uut (.*);

    always #2.5 clk = ~clk;

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model: expected output for a byte accepted in mode m.
    task automatic model_push(input logic [1:0] m, input logic [7:0] b);
        if (b == CR && m[0]) begin
            exp_q.push_back(NL); tag_q.push_back(mode_tag(m));
        end else if (b == NL && m[1]) begin
            exp_q.push_back(CR); tag_q.push_back(mode_tag(m));
            exp_q.push_back(NL); tag_q.push_back(mode_tag(m));
        end else begin
            exp_q.push_back(b); tag_q.push_back(mode_tag(m));
        end
    endtask

    // One cycle from a negedge: sample handshakes, cross the edge, score.
    task automatic cyc(input bit use_model);
        logic [1:0] m;
        logic [7:0] d;
        #1;
        in_fire_s  = in_valid & in_ready;
        out_fire_s = out_valid & out_ready;
        out_data_s = out_data;
        m = mode;
        d = in_data;
        @(posedge clk);
        if (in_fire_s && use_model) model_push(m, d);
        if (out_fire_s) begin
            if (exp_q.size() == 0) begin
                check("R6 extra output", out_data_s, 8'hXX);
            end else begin
                check(tag_q.pop_front(), out_data_s, exp_q.pop_front());
            end
        end
        @(negedge clk);
    endtask

    task automatic drain(input int n);
        out_ready = 1'b1;
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 out_valid", {7'd0, out_valid}, 8'd0);
        check("R1 in_ready", {7'd0, in_ready}, 8'd1);
        @(negedge clk);

        // Vector table walk: expectations come from the table itself.
        for (int v = 0; v < NV; v++) begin
            mode = VEC[v][25:24];
            exp_q.push_back(VEC[v][15:8]); tag_q.push_back(mode_tag(mode));
            if (VEC[v][7:0] != 8'h00) begin
                exp_q.push_back(VEC[v][7:0]); tag_q.push_back(mode_tag(mode));
            end
            in_valid = 1'b1;
            in_data  = VEC[v][23:16];
            out_ready = 1'b1;
            while (!(in_valid && in_ready)) cyc(1'b0);
            cyc(1'b0);
            in_valid = 1'b0;
            for (int k = 0; k < 4; k++) cyc(1'b0);
        end
        check("R2 table drained", 8'(exp_q.size()), 8'd0);

        // R10 latency and R9 ready path under a stall.
        mode = 2'b00; out_ready = 1'b0;
        in_valid = 1'b1; in_data = 8'h41;
        cyc(1'b1);
        in_valid = 1'b0;
        #1;
        check("R10 out_valid", {7'd0, out_valid}, 8'd1);
        check("R10 out_data", out_data, 8'h41);
        check("R9 in_ready stalled", {7'd0, in_ready}, 8'd0);
        @(negedge clk);
        drain(3);
        #1;
        check("R9 in_ready idle", {7'd0, in_ready}, 8'd1);
        @(negedge clk);

        // R7/R6/R8: expansion stalled, mode flipped mid-expansion.
        mode = 2'b10; out_ready = 1'b0;
        in_valid = 1'b1; in_data = NL;
        cyc(1'b1);
        in_valid = 1'b0;
        mode = 2'b00;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R6 in_ready low on CR", {7'd0, in_ready}, 8'd0);
            check("R8 stable CR", out_data, CR);
            @(negedge clk);
        end
        out_ready = 1'b1;
        cyc(1'b1);
        out_ready = 1'b0;
        #1;
        check("R6 in_ready low on NL", {7'd0, in_ready}, 8'd0);
        check("R7 trailing NL", out_data, NL);
        @(negedge clk);
        drain(3);
        check("R7 expansion complete", 8'(exp_q.size()), 8'd0);

        // Back-to-back NLs and random traffic in all modes, random backpressure.
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            for (int n = 0; n < 300; ) begin
                if (!in_valid && ($urandom_range(0, 3) != 0)) begin
                    in_valid = 1'b1;
                    case ($urandom_range(0, 3))
                        0: in_data = NL;
                        1: in_data = CR;
                        default: in_data = 8'($urandom);
                    endcase
                end
                out_ready = ($urandom_range(0, 2) != 0);
                cyc(1'b1);
                if (in_fire_s) begin
                    in_valid = 1'b0;
                    n++;
                end
            end
            in_valid = 1'b0;
            drain(10);
            check({mode_tag(mode), " scoreboard drained"}, 8'(exp_q.size()), 8'd0);
        end

        // R1 reset in the middle of a stalled expansion.
        mode = 2'b11; out_ready = 1'b0;
        in_valid = 1'b1; in_data = NL;
        cyc(1'b0);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 out_valid after reset", {7'd0, out_valid}, 8'd0);
        check("R1 in_ready after reset", {7'd0, in_ready}, 8'd1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule